// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits on the receive path of an Ethernet MAC and decides, while the destination address is still arriving, whether the frame belongs to this station. Address bytes are presented one per valid cycle, and a start marker flags the first byte. The block compares the address byte by byte against a programmed station address. At the same time it runs a CRC-32 over the same bytes. Group addresses are accepted through a 64-bit hash table indexed by six bits of that CRC, not by exact match.

The filter is configured through a small byte-wide write port. The writable state is six station address bytes, eight hash table bytes and a receive mode byte. The mode byte enables broadcast acceptance, multicast acceptance, promiscuous reception of any unicast address, and a monitor mode. In monitor mode, frames are judged but not stored; each accepted frame instead increments a missed-frame counter.

One cycle after the sixth address byte, the block pulses a done flag. Alongside it, it presents the accept decision, a store decision and a group-address indication. These three stay valid until the next decision.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, dec_done, dec_accept, dec_group, dec_store and miss_count are 0, and the station address, hash table and mode byte are all 0.
- R2: A write with cfg_we high stores cfg_wdata at selector cfg_sel. Selectors 0 to 5 hold station byte k, compared against the k-th received byte. Selectors 8 to 15 hold hash byte 0 to 7. Selector 16 holds the mode byte. In the mode byte, 0x04 accepts broadcast, 0x08 accepts multicast, 0x10 is promiscuous and 0x20 is monitor; the other mode bits have no effect.
- R3: A byte counts only when rx_valid is high. rx_sof with rx_valid marks byte 0 and restarts the address at any time. dec_done is high exactly in the cycle after the sixth byte. Valid bytes after the sixth, or before any rx_sof, are ignored.
- R4: A physical address (bit 0 of the first byte clear) that equals the station address is accepted.
- R5: With the promiscuous bit set, every physical address is accepted. Without it, a physical address that differs from the station address is rejected.
- R6: The all-ones address is accepted if and only if the broadcast bit is set, whatever the hash table and the multicast bit hold.
- R7: Any other group address is accepted only when the multicast bit is set and the indexed table bit is 1. The index is computed as follows. A CRC-32 register starts at all ones and processes each byte LSB first, using the reflected polynomial 0xEDB88320 with no final inversion. Register bit k becomes index bit 5-k. Index n selects hash byte n/8, bit n%8.
- R8: With all eight hash bytes at 0xFF and the multicast bit set, every group address is accepted. With all eight bytes at 0, no non-broadcast group address is accepted.
- R9: dec_group equals bit 0 of the first address byte, so it is 1 for multicast and broadcast and 0 for physical.
- R10: dec_store equals dec_accept with the monitor bit clear. An accepted decision with monitor set increments miss_count by one, wrapping at its width; otherwise miss_count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Configuration byte selector |
| cfg_wdata | input | 8 | Configuration write data |
| rx_sof | input | 1 | Marks the first destination byte |
| rx_valid | input | 1 | Destination byte valid |
| rx_byte | input | 8 | Destination address byte |
| dec_done | output | 1 | One-cycle pulse: decision ready |
| dec_accept | output | 1 | Frame accepted by the filter |
| dec_group | output | 1 | Destination is a group address |
| dec_store | output | 1 | Accepted and not in monitor mode |
| miss_count | output | 8 | Monitor-mode accepted frame counter |

## Verification
The assertions check several rules on every cycle:
- the decision pulse never lasts two cycles and always follows a valid byte;
- a stored frame is always an accepted one;
- the missed-frame counter moves only with an accepted decision that is not stored, and then by exactly one.

The accept value itself depends on the CRC, the table contents and the mode. Only the bench scenarios can show it. The bench compares each decision against its own CRC and filter model across physical, broadcast and hashed group addresses. It also covers the restart, trailing-byte and monitor cases.

// File: rtl/af_pkg.sv
// Shared constants and types for the destination address filter.
// Assumes byte-wide configuration selectors and an 8-bit mode byte.
package af_pkg;
    localparam int SEL_W     = 5;
    localparam int HASH_BASE = 8;   // first hash table selector
    localparam int MODE_SEL  = 16;  // mode byte selector
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    // decoded mode byte
    typedef struct packed {
        logic monitor;   // 0x20
        logic promisc;   // 0x10
        logic mcast;     // 0x08
        logic bcast;     // 0x04
    } af_mode_t;
endpackage

// File: rtl/af_regfile.sv
// Configuration storage: station address bytes, hash table bytes, mode.
// Assumes ADDR_BYTES <= HASH_BASE and HASH_BASE + HASH_BYTES <= MODE_SEL.
module af_regfile #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BYTES = 8,
    localparam int HASH_BITS = HASH_BYTES * 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [af_pkg::SEL_W-1:0]   sel,
    input  logic [7:0]                 wdata,
    output logic [ADDR_BYTES*8-1:0]    station,
    output logic [HASH_BITS-1:0]       table_bits,
    output af_pkg::af_mode_t           mode
);
    import af_pkg::*;

    // one register per station byte
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_sta
        // write station byte i
        always_ff @(posedge clk) begin
            if (!rst_n)
                station[i*8 +: 8] <= '0;
            else if (we && sel == SEL_W'(i))
                station[i*8 +: 8] <= wdata;
        end
    end

    // one register per hash byte
    for (genvar j = 0; j < HASH_BYTES; j++) begin : g_hash
        // write hash byte j
        always_ff @(posedge clk) begin
            if (!rst_n)
                table_bits[j*8 +: 8] <= '0;
            else if (we && sel == SEL_W'(HASH_BASE + j))
                table_bits[j*8 +: 8] <= wdata;
        end
    end

    // write the mode byte, keeping only the used bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= '0;
        else if (we && sel == SEL_W'(MODE_SEL))
            mode <= wdata[5:2];
    end
endmodule

// File: rtl/af_crc_acc.sv
// Reflected CRC-32 accumulator over address bytes, LSB first.
// crc_next is the register value including the current byte; a start
// byte seeds from all ones. No final inversion is applied.
module af_crc_acc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        start,
    input  logic [7:0]  din,
    output logic [31:0] crc_next
);
    import af_pkg::*;

    logic [31:0] crc_q;

    // combinational byte update, eight serial steps
    always_comb begin
        logic [31:0] c;
        c = start ? 32'hFFFF_FFFF : crc_q;
        for (int b = 0; b < 8; b++)
            c = (c[0] ^ din[b]) ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        crc_next = c;
    end

    // hold the running CRC between bytes
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= 32'hFFFF_FFFF;
        else if (en)
            crc_q <= crc_next;
    end
endmodule

// File: rtl/af_decide.sv
// Combinational accept decision from address class flags and mode.
// Assumes the flags describe the complete destination address.
module af_decide (
    input  af_pkg::af_mode_t mode,
    input  logic             is_group,
    input  logic             is_bcast,
    input  logic             sta_match,
    input  logic             hash_hit,
    output logic             accept
);
    // priority: broadcast, then group hash, then physical
    always_comb begin
        if (is_bcast)
            accept = mode.bcast;
        else if (is_group)
            accept = mode.mcast && hash_hit;
        else
            accept = mode.promisc || sta_match;
    end
endmodule

// File: rtl/mcast_hash_filter.sv
// Destination address filter: tracks the address bytes of a frame,
// matches them against the station address, hashes them for group
// addresses and registers the decision one cycle after the last byte.
// Assumes bytes arrive in wire order starting with rx_sof.
module mcast_hash_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BYTES = 8,
    parameter int MISS_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [af_pkg::SEL_W-1:0] cfg_sel,
    input  logic [7:0]               cfg_wdata,
    input  logic                     rx_sof,
    input  logic                     rx_valid,
    input  logic [7:0]               rx_byte,
    output logic                     dec_done,
    output logic                     dec_accept,
    output logic                     dec_group,
    output logic                     dec_store,
    output logic [MISS_W-1:0]        miss_count
);
    import af_pkg::*;

    localparam int HASH_BITS = HASH_BYTES * 8;
    localparam int IDX_W     = $clog2(HASH_BITS);
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1);

    logic [ADDR_BYTES*8-1:0] station;
    logic [HASH_BITS-1:0]    table_bits;
    af_mode_t                mode;
    logic [31:0]             crc_next;
    logic [CNT_W-1:0]        cnt_q, pos;
    logic                    take, last;
    logic                    match_q, ones_q, grp_q;
    logic                    match_now, ones_now, grp_now;
    logic [IDX_W-1:0]        idx;
    logic                    accept_now;

    af_regfile #(.ADDR_BYTES(ADDR_BYTES), .HASH_BYTES(HASH_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .station(station), .table_bits(table_bits),
        .mode(mode)
    );

    af_crc_acc u_crc (
        .clk(clk), .rst_n(rst_n), .en(take), .start(rx_sof),
        .din(rx_byte), .crc_next(crc_next)
    );

    // byte acceptance and position within the address
    always_comb begin
        take = rx_valid && (rx_sof || (cnt_q != '0 && cnt_q < CNT_W'(ADDR_BYTES)));
        pos  = rx_sof ? '0 : cnt_q;
        last = take && (pos == CNT_W'(ADDR_BYTES - 1));
    end

    // running class flags including the current byte
    always_comb begin
        match_now = (rx_byte == station[pos*8 +: 8]) && (rx_sof || match_q);
        ones_now  = (rx_byte == 8'hFF) && (rx_sof || ones_q);
        grp_now   = rx_sof ? rx_byte[0] : grp_q;
    end

    // hash index is the low CRC bits in reversed order
    for (genvar k = 0; k < IDX_W; k++) begin : g_rev
        assign idx[k] = crc_next[IDX_W-1-k];
    end

    af_decide u_dec (
        .mode(mode), .is_group(grp_now), .is_bcast(ones_now),
        .sta_match(match_now), .hash_hit(table_bits[idx]),
        .accept(accept_now)
    );

    // byte counter and running flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            match_q <= 1'b0;
            ones_q  <= 1'b0;
            grp_q   <= 1'b0;
        end else if (take) begin
            cnt_q   <= pos + 1'b1;
            match_q <= match_now;
            ones_q  <= ones_now;
            grp_q   <= grp_now;
        end
    end

    // registered decision and monitor-mode counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_done   <= 1'b0;
            dec_accept <= 1'b0;
            dec_group  <= 1'b0;
            dec_store  <= 1'b0;
            miss_count <= '0;
        end else begin
            dec_done <= last;
            if (last) begin
                dec_accept <= accept_now;
                dec_group  <= grp_now;
                dec_store  <= accept_now && !mode.monitor;
                if (accept_now && mode.monitor)
                    miss_count <= miss_count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/af_checker.sv
// Cycle-level checks on the filter's outputs, bound to the top module.
module af_checker #(
    parameter int MISS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              dec_done,
    input logic              dec_accept,
    input logic              dec_store,
    input logic [MISS_W-1:0] miss_count
);
    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> !dec_done);
    // R3
    done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |-> $past(rx_valid));
    // R10
    store_implies_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_store |-> dec_accept);
    // R10
    miss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_done |-> $stable(miss_count));
    // R10
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && dec_accept && !dec_store) |-> miss_count == $past(miss_count) + 1'b1);
    // R10
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && !(dec_accept && !dec_store)) |-> $stable(miss_count));
endmodule

bind mcast_hash_filter af_checker #(.MISS_W(MISS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .dec_done(dec_done),
    .dec_accept(dec_accept), .dec_store(dec_store), .miss_count(miss_count)
);

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_sof = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       dec_done, dec_accept, dec_group, dec_store;
    logic [7:0] miss_count;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    logic [47:0] sta;
    logic [63:0] tbl;
    logic [7:0]  mode;

    always #2.5 clk = ~clk;

    mcast_hash_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .dec_done(dec_done), .dec_accept(dec_accept),
        .dec_group(dec_group), .dec_store(dec_store), .miss_count(miss_count)
    );

    // vectors: {mode byte, destination (first byte in bits 47:40)}
    localparam logic [55:0] VEC [10] = '{
        {8'h00, 48'h001A2B3C4D5E},   // own physical
        {8'h00, 48'h001A2B3C4D5F},   // other physical, rejected
        {8'h10, 48'h0200DEADBEEF},   // promiscuous
        {8'h04, 48'hFFFFFFFFFFFF},   // broadcast accepted
        {8'h08, 48'hFFFFFFFFFFFF},   // broadcast without bcast bit
        {8'h08, 48'h01005E000001},   // group via hash
        {8'h08, 48'h333300000001},   // group via hash
        {8'h00, 48'h01005E000001},   // group, mcast bit off
        {8'h0C, 48'h01005E7F0102},   // group via hash
        {8'hC3, 48'h001A2B3C4D5E}    // unused mode bits only
    };

    function automatic logic [5:0] hidx(input logic [47:0] d);
        logic [31:0] c = 32'hFFFFFFFF;
        logic [5:0]  r;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = d[47-8*i -: 8];
            for (int j = 0; j < 8; j++)
                c = (c[0] ^ b[j]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        for (int k = 0; k < 6; k++) r[5-k] = c[k];
        return r;
    endfunction

    function automatic logic model_acc(input logic [7:0] m, input logic [47:0] d);
        if (d == 48'hFFFFFFFFFFFF) return m[2];
        if (d[40]) return m[3] && tbl[hidx(d)];
        return m[4] || (d == sta);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] s, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic set_mode(input logic [7:0] m);
        mode = m; wr(5'd16, m);
    endtask

    task automatic set_tbl(input logic [63:0] t);
        tbl = t;
        for (int i = 0; i < 8; i++) wr(5'(8 + i), t[i*8 +: 8]);
    endtask

    // send six bytes; returns at the negedge where dec_done is high
    task automatic send(input logic [47:0] d);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = d[47-8*i -: 8];
        end
        @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0;
    endtask

    task automatic check_dec(input string req, input logic [7:0] m, input logic [47:0] d);
        logic a = model_acc(m, d);
        chk(req, 32'(dec_done), 32'd1);
        chk(req, 32'(dec_accept), 32'(a));
        chk("R9", 32'(dec_group), 32'(d[40]));
        chk("R10", 32'(dec_store), 32'(a && !m[5]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] g;
        logic [7:0] m0;
        sta = 48'h001A2B3C4D5E; tbl = '0; mode = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", 32'(dec_done), 0); chk("R1", 32'(dec_accept), 0);
        chk("R1", 32'(dec_store), 0); chk("R1", 32'(miss_count), 0);
        rst_n = 1'b1;
        // R1: registers zero, so the own address does not yet match
        send(sta);
        chk("R1", 32'(dec_accept), 0);

        // R2 program station bytes in receive order
        for (int i = 0; i < 6; i++) wr(5'(i), sta[47-8*i -: 8]);
        g = 48'h01005E000001;
        set_tbl(64'h1 << hidx(g));
        g = 48'h333300000001;
        tbl[hidx(g)] = 1'b1;
        set_tbl(tbl);
        g = 48'h01005E7F0102;
        tbl[hidx(g)] = 1'b1;
        set_tbl(tbl);

        // vector walk: R2 R4 R5 R6 R7
        foreach (VEC[v]) begin
            set_mode(VEC[v][55:48]);
            send(VEC[v][47:0]);
            check_dec("R4/R5/R6/R7", VEC[v][55:48], VEC[v][47:0]);
        end

        // R7: group whose hash bit is clear is rejected
        set_mode(8'h08);
        g = 48'h01005E000001;
        set_tbl(~(64'h1 << hidx(g)));
        send(g); chk("R7", 32'(dec_accept), 0);

        // R6: broadcast ignores table and mcast bit
        set_tbl(64'hFFFFFFFFFFFFFFFF);
        send(48'hFFFFFFFFFFFF); chk("R6", 32'(dec_accept), 0);

        // R8 all-ones table accepts any group
        for (int i = 0; i < 8; i++) begin
            send({8'h01 | 8'(i*16), 40'h0123456789 ^ 40'(i*771)});
            chk("R8", 32'(dec_accept), 1);
        end
        set_tbl('0);
        send(48'h01005E000001); chk("R8", 32'(dec_accept), 0);
        send(48'h2BCDEF012345); chk("R8", 32'(dec_accept), 0);

        // R3 restart: sof in the middle begins a new address
        set_mode(8'h00);
        @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b1; rx_byte = 8'hAA;
        @(negedge clk); rx_sof = 1'b0; rx_byte = 8'hBB;
        send(sta);
        chk("R3", 32'(dec_accept), 1);
        @(negedge clk); chk("R3", 32'(dec_done), 0);

        // R3 gaps and trailing bytes
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = sta[47-8*i -: 8];
            @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_byte = 8'h99;
            if (i < 5) chk("R3", 32'(dec_done), 0);
        end
        chk("R3", 32'(dec_done), 1); chk("R3", 32'(dec_accept), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_byte = 8'(i);
            chk("R3", 32'(dec_done), 0);
        end
        @(negedge clk); rx_valid = 1'b0;
        chk("R3", 32'(dec_done), 0);

        // R10 monitor mode counts and does not store
        m0 = miss_count;
        set_mode(8'h20);
        send(sta); chk("R10", 32'(dec_store), 0); chk("R10", 32'(miss_count), 32'(m0 + 8'd1));
        send(48'h001A2B3C4D00); chk("R10", 32'(miss_count), 32'(m0 + 8'd1));
        set_mode(8'h00);
        send(sta); chk("R10", 32'(dec_store), 1); chk("R10", 32'(miss_count), 32'(m0 + 8'd1));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule